// File: doc/BRIEF.md
# Per-Core Power Domain Sequencer

This block switches the power domain of one processor core off or on in response to a request. It drives four controls per core: an isolation clamp, a power-switch request, a power-ready flag and a reset-release bit, where the core is held in reset while the reset-release bit is low. Each step that changes a control is followed by a confirmation step. The confirmation step samples the matching acknowledge input from the analog power logic until that input reaches the expected level, or until a bounded sample budget runs out.

A request names a core by cluster number and local core number. The absolute index is `cluster * CORES_PER_CLUSTER + local`. A separate early-boot request runs a batch that switches off the secondary cores, one after another. Before power-up, an optional pre-step loads an 8-bit switch-finger field and then waits for a settle time. Both settle waits last `SETTLE_US * CLK_MHZ` cycles.

States are `S_IDLE`, `S_PD_ISO`, `S_PD_ISO_CHK`, `S_PD_SW`, `S_PD_SW_CHK`, `S_PD_RDY`, `S_PD_RST`, `S_PD_RST_CHK`, `S_BOOT_NEXT`, `S_PU_FING`, `S_PU_FING_WAIT`, `S_PU_SW`, `S_PU_WAIT`, `S_PU_RDY`, `S_PU_RDY_CHK`, `S_PU_ISO`, `S_PU_ISO_CHK`, `S_PU_RST`, `S_PU_RST_CHK`, `S_FIN_OK` and `S_FIN_ERR`.

Transitions:
- Idle: `S_IDLE` goes to `S_PD_ISO` on a boot request or an off request. On an on request it goes to `S_PU_FING` when the finger pre-step is built, otherwise to `S_PU_SW`.
- Action states: every state that changes a control moves to its check state on the next cycle.
- Check states: a check state advances when the acknowledge matches. On budget expiry it goes to `S_FIN_ERR` for the switch-off, ready and reset checks, and advances anyway for either isolation check.
- Wait states: each wait state advances after `SETTLE_CYC` cycles.
- Batch continuation: `S_PD_RST_CHK` goes to `S_BOOT_NEXT` in batch mode. `S_BOOT_NEXT` either loops to `S_PD_ISO` for the next core or goes to `S_FIN_OK`.
- Finish: both finish states return to `S_IDLE`.

Top module: `core_pwr_seq`

## Requirements
- R1: After reset the block is idle with busy, done and err low. Every core is powered: iso_en=0, sw_req=1, pwr_rdy=1 and rst_rel=1. finger_field is 0.
- R2: The target core index is req_cluster*CORES_PER_CLUSTER+req_local. Only the target core's controls change during a request, and no control changes while the block is idle.
- R3: Power-down order for the target: set iso_en, confirm iso_ack=1, clear sw_req, confirm sw_ack=0, clear pwr_rdy, clear rst_rel, confirm rst_ack=0, then pulse done.
- R4: Power-up order for the target: set sw_req, wait SETTLE_CYC cycles, set pwr_rdy, confirm rdy_ack=1, clear iso_en, confirm iso_ack=0, set rst_rel, confirm rst_ack=1, then pulse done. pwr_rdy rises SETTLE_CYC+1 cycles after sw_req rises.
- R5: A confirmation takes at most POLL_LIMIT samples. If the switch-off, ready or reset confirmation is still unmatched after that many samples, err rises exactly POLL_LIMIT cycles after the control changed, and no later step of the sequence is performed.
- R6: An isolation confirmation that runs out its budget, in either direction, does not abort. The next control changes POLL_LIMIT+1 cycles after the isolation control changed, and the sequence ends with done.
- R7: A request is accepted only when idle, and requests made while busy are ignored. busy is high from the accept edge through the single cycle in which done or err pulses. done and err are never high together.
- R8: A boot request powers down core 1. It then powers down cores 2 to NUM_CORES-1 only when cluster_off=0; when cluster_off=1 it stops after cluster 0. Core 0 is never touched, and the first failure ends the batch with err.
- R9: With the finger pre-step built, a power-up first loads finger_field with 8'hFC and waits SETTLE_CYC cycles. sw_req therefore rises SETTLE_CYC+2 cycles after busy rises.
- R10: A core whose sw_req is low always has iso_en high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a single-core request |
| req_on | input | 1 | 1 = power up, 0 = power down |
| req_cluster | input | CLW | Cluster number of the target |
| req_local | input | LW | Core number inside the cluster |
| boot_req | input | 1 | Start the early-boot power-down batch |
| cluster_off | input | 1 | Status bit: only cluster 0 is present |
| iso_ack | input | NUM_CORES | Isolation status per core |
| sw_ack | input | NUM_CORES | Power-switch status per core |
| rdy_ack | input | NUM_CORES | Power-ready status per core |
| rst_ack | input | NUM_CORES | Reset-release status per core |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse on success |
| err | output | 1 | One-cycle pulse on abort |
| iso_en | output | NUM_CORES | Isolation enable per core |
| sw_req | output | NUM_CORES | Power-switch request per core |
| pwr_rdy | output | NUM_CORES | Power-ready flag per core |
| rst_rel | output | NUM_CORES | Reset release per core (0 holds the core in reset) |
| finger_field | output | 8 | Switch-finger control field |

## Verification
The assertions assume that requests are only offered as single-cycle pulses, and that the acknowledge inputs depend on nothing but the controls and a stuck-at override. The bench respects this by modelling each acknowledge as its control delayed by a fixed three-cycle pipe. A fault is injected only by forcing one acknowledge of one core to a constant between requests, never in the middle of a sequence. Every core is swept through off and on, every timeout path and every batch outcome is exercised, and all cycle distances are computed from POLL_LIMIT and SETTLE_CYC.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [4:0] {
        S_IDLE,
        S_PD_ISO,
        S_PD_ISO_CHK,
        S_PD_SW,
        S_PD_SW_CHK,
        S_PD_RDY,
        S_PD_RST,
        S_PD_RST_CHK,
        S_BOOT_NEXT,
        S_PU_FING,
        S_PU_FING_WAIT,
        S_PU_SW,
        S_PU_WAIT,
        S_PU_RDY,
        S_PU_RDY_CHK,
        S_PU_ISO,
        S_PU_ISO_CHK,
        S_PU_RST,
        S_PU_RST_CHK,
        S_FIN_OK,
        S_FIN_ERR
    } seq_state_e;

endpackage

// File: rtl/pwr_seq_tick.sv
// Cycle counter that flags its terminal sample; cleared whenever run is low.
module pwr_seq_tick #(
    parameter int LIMIT = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (!last) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = run && (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/pwr_seq_boot.sv
// Picks the next core of the early-boot batch.
module pwr_seq_boot #(
    parameter int NUM_CORES         = 4,
    parameter int CORES_PER_CLUSTER = 2,
    parameter int IW                = 2
) (
    input  logic [IW-1:0] cur_idx,
    input  logic          single_cluster,
    output logic [IW-1:0] nxt_idx,
    output logic          has_more
);
    logic [IW:0] sum;
    logic [IW:0] limit;

    always_comb begin
        sum      = {1'b0, cur_idx} + 1'b1;
        limit    = single_cluster ? (IW+1)'(CORES_PER_CLUSTER) : (IW+1)'(NUM_CORES);
        nxt_idx  = sum[IW-1:0];
        has_more = (sum < limit);
    end

endmodule

// File: rtl/core_pwr_seq.sv
module core_pwr_seq
    import pwr_seq_pkg::*;
#(
    parameter int       NUM_CLUSTERS      = 2,
    parameter int       CORES_PER_CLUSTER = 2,
    parameter int       POLL_LIMIT        = 2000,
    parameter int       CLK_MHZ           = 50,
    parameter int       SETTLE_US         = 100,
    parameter bit       FINGER_STEP       = 1'b1,
    parameter bit [7:0] FINGER_CODE       = 8'hFC,
    localparam int      NUM_CORES         = NUM_CLUSTERS * CORES_PER_CLUSTER,
    localparam int      CLW               = (NUM_CLUSTERS > 1) ? $clog2(NUM_CLUSTERS) : 1,
    localparam int      LW                = (CORES_PER_CLUSTER > 1) ? $clog2(CORES_PER_CLUSTER) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_on,
    input  logic [CLW-1:0]       req_cluster,
    input  logic [LW-1:0]        req_local,
    input  logic                 boot_req,
    input  logic                 cluster_off,
    input  logic [NUM_CORES-1:0] iso_ack,
    input  logic [NUM_CORES-1:0] sw_ack,
    input  logic [NUM_CORES-1:0] rdy_ack,
    input  logic [NUM_CORES-1:0] rst_ack,
    output logic                 busy,
    output logic                 done,
    output logic                 err,
    output logic [NUM_CORES-1:0] iso_en,
    output logic [NUM_CORES-1:0] sw_req,
    output logic [NUM_CORES-1:0] pwr_rdy,
    output logic [NUM_CORES-1:0] rst_rel,
    output logic [7:0]           finger_field
);
    localparam int IW         = $clog2(NUM_CORES);
    localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;

    seq_state_e state_q, state_d;

    logic [IW-1:0] tgt_q;
    logic          boot_q;
    logic          single_q;
    logic [IW-1:0] req_idx;
    logic [IW-1:0] boot_nxt;
    logic          boot_more;
    logic          poll_run, poll_last;
    logic          wait_run, wait_last;
    logic          a_iso, a_sw, a_rdy, a_rst;

    always_comb begin
        req_idx = IW'(req_cluster) * IW'(CORES_PER_CLUSTER) + IW'(req_local);
    end

    assign a_iso = iso_ack[tgt_q];
    assign a_sw  = sw_ack[tgt_q];
    assign a_rdy = rdy_ack[tgt_q];
    assign a_rst = rst_ack[tgt_q];

    assign poll_run = (state_q == S_PD_ISO_CHK) || (state_q == S_PD_SW_CHK) ||
                      (state_q == S_PD_RST_CHK) || (state_q == S_PU_RDY_CHK) ||
                      (state_q == S_PU_ISO_CHK) || (state_q == S_PU_RST_CHK);
    assign wait_run = (state_q == S_PU_FING_WAIT) || (state_q == S_PU_WAIT);

    pwr_seq_tick #(.LIMIT(POLL_LIMIT)) u_poll (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (poll_run),
        .last (poll_last)
    );

    pwr_seq_tick #(.LIMIT(SETTLE_CYC)) u_settle (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (wait_run),
        .last (wait_last)
    );

    pwr_seq_boot #(
        .NUM_CORES        (NUM_CORES),
        .CORES_PER_CLUSTER(CORES_PER_CLUSTER),
        .IW               (IW)
    ) u_boot (
        .cur_idx       (tgt_q),
        .single_cluster(single_q),
        .nxt_idx       (boot_nxt),
        .has_more      (boot_more)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (boot_req) begin
                    state_d = S_PD_ISO;
                end else if (req_valid) begin
                    if (!req_on)          state_d = S_PD_ISO;
                    else if (FINGER_STEP) state_d = S_PU_FING;
                    else                  state_d = S_PU_SW;
                end
            end
            S_PD_ISO:     state_d = S_PD_ISO_CHK;
            S_PD_ISO_CHK: if (a_iso || poll_last) state_d = S_PD_SW;
            S_PD_SW:      state_d = S_PD_SW_CHK;
            S_PD_SW_CHK: begin
                if (!a_sw)          state_d = S_PD_RDY;
                else if (poll_last) state_d = S_FIN_ERR;
            end
            S_PD_RDY:     state_d = S_PD_RST;
            S_PD_RST:     state_d = S_PD_RST_CHK;
            S_PD_RST_CHK: begin
                if (!a_rst)         state_d = boot_q ? S_BOOT_NEXT : S_FIN_OK;
                else if (poll_last) state_d = S_FIN_ERR;
            end
            S_BOOT_NEXT:    state_d = boot_more ? S_PD_ISO : S_FIN_OK;
            S_PU_FING:      state_d = S_PU_FING_WAIT;
            S_PU_FING_WAIT: if (wait_last) state_d = S_PU_SW;
            S_PU_SW:        state_d = S_PU_WAIT;
            S_PU_WAIT:      if (wait_last) state_d = S_PU_RDY;
            S_PU_RDY:       state_d = S_PU_RDY_CHK;
            S_PU_RDY_CHK: begin
                if (a_rdy)          state_d = S_PU_ISO;
                else if (poll_last) state_d = S_FIN_ERR;
            end
            S_PU_ISO:     state_d = S_PU_ISO_CHK;
            S_PU_ISO_CHK: if (!a_iso || poll_last) state_d = S_PU_RST;
            S_PU_RST:     state_d = S_PU_RST_CHK;
            S_PU_RST_CHK: begin
                if (a_rst)          state_d = S_FIN_OK;
                else if (poll_last) state_d = S_FIN_ERR;
            end
            S_FIN_OK:  state_d = S_IDLE;
            S_FIN_ERR: state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Output and context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q    <= '0;
            boot_q   <= 1'b0;
            single_q <= 1'b0;
            iso_en   <= '0;
            sw_req   <= '1;
            pwr_rdy  <= '1;
            rst_rel  <= '1;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (boot_req) begin
                        tgt_q    <= IW'(1);
                        boot_q   <= 1'b1;
                        single_q <= cluster_off;
                    end else if (req_valid) begin
                        tgt_q  <= req_idx;
                        boot_q <= 1'b0;
                    end
                end
                S_PD_ISO:    iso_en[tgt_q]  <= 1'b1;
                S_PD_SW:     sw_req[tgt_q]  <= 1'b0;
                S_PD_RDY:    pwr_rdy[tgt_q] <= 1'b0;
                S_PD_RST:    rst_rel[tgt_q] <= 1'b0;
                S_BOOT_NEXT: if (boot_more) tgt_q <= boot_nxt;
                S_PU_SW:     sw_req[tgt_q]  <= 1'b1;
                S_PU_RDY:    pwr_rdy[tgt_q] <= 1'b1;
                S_PU_ISO:    iso_en[tgt_q]  <= 1'b0;
                S_PU_RST:    rst_rel[tgt_q] <= 1'b1;
                default: ;
            endcase
        end
    end

    generate
        if (FINGER_STEP) begin : g_finger
            logic [7:0] fing_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                  fing_q <= 8'h00;
                else if (state_q == S_PU_FING) fing_q <= FINGER_CODE;
            end
            assign finger_field = fing_q;
        end else begin : g_no_finger
            assign finger_field = 8'h00;
        end
    endgenerate

    assign busy = (state_q != S_IDLE);
    assign done = (state_q == S_FIN_OK);
    assign err  = (state_q == S_FIN_ERR);

endmodule

// File: rtl/core_pwr_seq_chk.sv
module core_pwr_seq_chk #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         busy,
    input logic         done,
    input logic         err,
    input logic [N-1:0] iso_en,
    input logic [N-1:0] sw_req,
    input logic [N-1:0] rst_rel
);
    assert_pulse_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    assert_err_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err && !busy);

    assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && !err) |=> busy);

    assert_iso_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((~sw_req & ~iso_en) == '0));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(iso_en) && $stable(sw_req) && $stable(rst_rel)));

    assert_one_core_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0((iso_en ^ $past(iso_en)) | (sw_req ^ $past(sw_req)) |
                 (rst_rel ^ $past(rst_rel))));

endmodule

bind core_pwr_seq core_pwr_seq_chk #(.N(NUM_CORES)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .done   (done),
    .err    (err),
    .iso_en (iso_en),
    .sw_req (sw_req),
    .rst_rel(rst_rel)
);

// File: tb/core_pwr_seq_tb.sv
module core_pwr_seq_tb;
    localparam int N    = 4;
    localparam int POLL = 20;
    localparam int W    = 100;   // CLK_MHZ=1 * SETTLE_US=100
    localparam int LAT  = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0, req_on = 1'b0, boot_req = 1'b0, cluster_off = 1'b0;
    logic [0:0]   req_cluster = '0, req_local = '0;
    logic [N-1:0] iso_ack, sw_ack, rdy_ack, rst_ack;
    logic         busy, done, err;
    logic [N-1:0] iso_en, sw_req, pwr_rdy, rst_rel;
    logic [7:0]   finger_field;

    int checks = 0, errors = 0, cyc = 0;
    int stuck_kind = 0;
    logic [1:0] stuck_core = '0;
    logic stuck_val = 1'b0;

    always #10 clk = ~clk;

    core_pwr_seq #(
        .NUM_CLUSTERS(2), .CORES_PER_CLUSTER(2), .POLL_LIMIT(POLL),
        .CLK_MHZ(1), .SETTLE_US(100), .FINGER_STEP(1'b1), .FINGER_CODE(8'hFC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_on(req_on),
        .req_cluster(req_cluster), .req_local(req_local), .boot_req(boot_req),
        .cluster_off(cluster_off), .iso_ack(iso_ack), .sw_ack(sw_ack),
        .rdy_ack(rdy_ack), .rst_ack(rst_ack), .busy(busy), .done(done), .err(err),
        .iso_en(iso_en), .sw_req(sw_req), .pwr_rdy(pwr_rdy), .rst_rel(rst_rel),
        .finger_field(finger_field)
    );

    // Acknowledge model: each control delayed LAT cycles, with a stuck-at override
    logic [4*N-1:0] pipe [LAT];
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) pipe[i] <= {{N{1'b1}}, {N{1'b1}}, {N{1'b1}}, {N{1'b0}}};
        end else begin
            pipe[0] <= {rst_rel, pwr_rdy, sw_req, iso_en};
            for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
        end
    end

    always_comb begin
        {rst_ack, rdy_ack, sw_ack, iso_ack} = pipe[LAT-1];
        if (stuck_kind == 1) iso_ack[stuck_core] = stuck_val;
        if (stuck_kind == 2) sw_ack[stuck_core]  = stuck_val;
        if (stuck_kind == 3) rdy_ack[stuck_core] = stuck_val;
        if (stuck_kind == 4) rst_ack[stuck_core] = stuck_val;
    end

    // Change stamps, sampled away from the active edge
    int t_iso[N], t_sw[N], t_rdy[N], t_rst[N];
    int t_busy = 0, t_done = 0, t_err = 0;
    logic [N-1:0] p_iso = '0, p_sw = '1, p_rdy = '1, p_rst = '1;
    logic p_busy = 1'b0, p_done = 1'b0, p_err = 1'b0;

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (iso_en[i]  != p_iso[i]) t_iso[i] = cyc;
            if (sw_req[i]  != p_sw[i])  t_sw[i]  = cyc;
            if (pwr_rdy[i] != p_rdy[i]) t_rdy[i] = cyc;
            if (rst_rel[i] != p_rst[i]) t_rst[i] = cyc;
        end
        if (busy && !p_busy) t_busy = cyc;
        if (done && !p_done) t_done = cyc;
        if (err && !p_err)   t_err  = cyc;
        p_iso = iso_en; p_sw = sw_req; p_rdy = pwr_rdy; p_rst = rst_rel;
        p_busy = busy; p_done = done; p_err = err;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    task automatic chk_lt(input string tag, input int a, input int b);
        chk(a < b, tag, a, b);
    endtask

    // Packed view {iso,sw,rdy,rst}: up = 4'b0111, down = 4'b1000
    function automatic int core_bits(input int c);
        return int'({iso_en[c], sw_req[c], pwr_rdy[c], rst_rel[c]});
    endfunction

    task automatic core_is(input int c, input int exp_bits, input string tag);
        chk_eq(tag, core_bits(c), exp_bits);
    endtask

    task automatic wait_end(output logic got_done, output logic got_err);
        got_done = 1'b0;
        got_err  = 1'b0;
        for (int k = 0; k < 5000 && !(got_done || got_err); k++) begin
            @(negedge clk);
            got_done = done;
            got_err  = err;
        end
        @(negedge clk);
    endtask

    task automatic run_req(input logic on, input int core, output logic gd, output logic ge);
        @(negedge clk);
        req_on      = on;
        req_cluster = 1'(core / 2);
        req_local   = 1'(core % 2);
        req_valid   = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_end(gd, ge);
    endtask

    task automatic run_boot(input logic single, output logic gd, output logic ge);
        @(negedge clk);
        cluster_off = single;
        boot_req    = 1'b1;
        @(negedge clk);
        boot_req = 1'b0;
        wait_end(gd, ge);
    endtask

    task automatic unstick();
        @(negedge clk);
        stuck_kind = 0;
        repeat (LAT + 1) @(negedge clk);
    endtask

    localparam int UP = 7, DN = 8;

    initial begin
        logic gd, ge;
        for (int i = 0; i < N; i++) begin
            t_iso[i] = 0; t_sw[i] = 0; t_rdy[i] = 0; t_rst[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk_eq("R1 busy", int'(busy), 0);
        chk_eq("R1 done/err", int'({done, err}), 0);
        for (int c = 0; c < N; c++) core_is(c, UP, "R1 core powered");
        chk_eq("R1 finger", int'(finger_field), 0);

        // R2 R3 R4 R9: sweep every core through off then on
        for (int c = 0; c < N; c++) begin
            run_req(1'b0, c, gd, ge);
            chk_eq("R3 off done", int'({gd, ge}), 2);
            core_is(c, DN, "R2 R3 target off");
            for (int o = 0; o < N; o++) if (o != c) core_is(o, UP, "R2 others untouched");
            chk_lt("R3 iso before sw", t_iso[c], t_sw[c]);
            chk_lt("R3 sw before rdy", t_sw[c], t_rdy[c]);
            chk_lt("R3 rdy before rst", t_rdy[c], t_rst[c]);
            chk_lt("R3 rst before done", t_rst[c], t_done);

            run_req(1'b1, c, gd, ge);
            chk_eq("R4 on done", int'({gd, ge}), 2);
            core_is(c, UP, "R4 target on");
            chk_eq("R9 finger code", int'(finger_field), 8'hFC);
            chk_eq("R9 sw after finger wait", t_sw[c] - t_busy, W + 2);
            chk_eq("R4 settle wait", t_rdy[c] - t_sw[c], W + 1);
            chk_lt("R4 rdy before iso", t_rdy[c], t_iso[c]);
            chk_lt("R4 iso before rst", t_iso[c], t_rst[c]);
            chk_lt("R4 rst before done", t_rst[c], t_done);
        end

        // R7: a request while busy is ignored
        @(negedge clk);
        req_on = 1'b0; req_cluster = 1'b0; req_local = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        req_cluster = 1'b1; req_local = 1'b1; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_end(gd, ge);
        chk_eq("R7 first request done", int'({gd, ge}), 2);
        core_is(3, UP, "R7 busy request ignored");
        repeat (5) @(negedge clk);
        chk_eq("R7 stays idle", int'(busy), 0);
        run_req(1'b1, 0, gd, ge);

        // R6: isolation-set confirmation timeout on power-down does not abort
        stuck_kind = 1; stuck_core = 2'd0; stuck_val = 1'b0;
        run_req(1'b0, 0, gd, ge);
        chk_eq("R6 pd iso timeout ends done", int'({gd, ge}), 2);
        chk_eq("R6 pd iso budget", t_sw[0] - t_iso[0], POLL + 1);
        unstick();
        run_req(1'b1, 0, gd, ge);

        // R5: switch-off timeout aborts before ready drops
        stuck_kind = 2; stuck_core = 2'd1; stuck_val = 1'b1;
        run_req(1'b0, 1, gd, ge);
        chk_eq("R5 sw timeout err", int'({gd, ge}), 1);
        chk_eq("R5 sw budget", t_err - t_sw[1], POLL);
        chk_eq("R5 sw abort leaves rdy/rst", int'({pwr_rdy[1], rst_rel[1]}), 3);
        unstick();
        run_req(1'b1, 1, gd, ge);
        chk_eq("R5 recover core1", int'({gd, ge}), 2);

        // R5: reset confirmation timeout on power-down
        stuck_kind = 4; stuck_core = 2'd2; stuck_val = 1'b1;
        run_req(1'b0, 2, gd, ge);
        chk_eq("R5 pd rst timeout err", int'({gd, ge}), 1);
        chk_eq("R5 pd rst budget", t_err - t_rst[2], POLL);
        core_is(2, DN, "R5 pd rst state");
        unstick();
        run_req(1'b1, 2, gd, ge);

        // R5: ready timeout on power-up aborts before isolation release
        run_req(1'b0, 3, gd, ge);
        stuck_kind = 3; stuck_core = 2'd3; stuck_val = 1'b0;
        run_req(1'b1, 3, gd, ge);
        chk_eq("R5 rdy timeout err", int'({gd, ge}), 1);
        chk_eq("R5 rdy budget", t_err - t_rdy[3], POLL);
        chk_eq("R5 rdy abort keeps iso/rst", int'({iso_en[3], rst_rel[3]}), 2);
        unstick();
        run_req(1'b1, 3, gd, ge);
        core_is(3, UP, "R5 recover core3");

        // R6: isolation-release timeout on power-up does not abort
        run_req(1'b0, 0, gd, ge);
        stuck_kind = 1; stuck_core = 2'd0; stuck_val = 1'b1;
        run_req(1'b1, 0, gd, ge);
        chk_eq("R6 pu iso timeout ends done", int'({gd, ge}), 2);
        chk_eq("R6 pu iso budget", t_rst[0] - t_iso[0], POLL + 1);
        core_is(0, UP, "R6 pu continues");
        unstick();

        // R5: reset-release timeout on power-up
        run_req(1'b0, 1, gd, ge);
        stuck_kind = 4; stuck_core = 2'd1; stuck_val = 1'b0;
        run_req(1'b1, 1, gd, ge);
        chk_eq("R5 pu rst timeout err", int'({gd, ge}), 1);
        chk_eq("R5 pu rst budget", t_err - t_rst[1], POLL);
        unstick();
        run_req(1'b1, 1, gd, ge);

        // R8: boot batch with a second cluster present
        run_boot(1'b0, gd, ge);
        chk_eq("R8 boot dual done", int'({gd, ge}), 2);
        core_is(0, UP, "R8 core0 kept");
        for (int c = 1; c < N; c++) core_is(c, DN, "R8 secondary off");
        chk_lt("R8 core1 before core2", t_rst[1], t_iso[2]);
        chk_lt("R8 core2 before core3", t_rst[2], t_iso[3]);
        for (int c = 1; c < N; c++) run_req(1'b1, c, gd, ge);

        // R8: single cluster stops after core 1
        run_boot(1'b1, gd, ge);
        chk_eq("R8 boot single done", int'({gd, ge}), 2);
        core_is(1, DN, "R8 single core1 off");
        core_is(2, UP, "R8 single core2 kept");
        core_is(3, UP, "R8 single core3 kept");
        run_req(1'b1, 1, gd, ge);

        // R8: first failure ends the batch
        stuck_kind = 2; stuck_core = 2'd2; stuck_val = 1'b1;
        run_boot(1'b0, gd, ge);
        chk_eq("R8 boot fail err", int'({gd, ge}), 1);
        core_is(1, DN, "R8 fail core1 off");
        core_is(2, 4'b1011, "R8 fail core2 partial");
        core_is(3, UP, "R8 fail core3 untouched");
        unstick();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", 150000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule